// File: doc/BRIEF.md
# Programmable Status Pin Flag Combiner

This block drives a bank of status output pins. Each pin has its own control field. The field picks which internal status indications can raise that pin. The block takes three global flags: frequency lock, phase lock and an interrupt request. It also takes three monitor flags (invalid, loss of reference, out of limits) for each of two references, A and B. Each pin's field chooses one of the two references as the source of its monitor flags, and sets an enable for each of the six flag kinds. The pin then shows the OR of every enabled flag.

The control fields are loaded through a plain register-write port made of an address, a data word and a write enable. Each pin output comes from a register, so it follows flag and control changes with a fixed one-clock delay. There is no state machine. The only sequential state is the control field of each pin and the registered pin value.

Top module: `status_pin_combiner`

## Requirements
- R1: There are NUM_PINS (default 4) independent 7-bit control fields. A write with `cfg_we` high loads `cfg_wdata` into the field whose index equals `cfg_addr`, at the next rising clock edge. Every other field is left unchanged.
- R2: Control field layout: bit 0 enables frequency lock, bit 1 enables phase lock, bit 2 enables reference invalid, bit 3 enables loss of reference, bit 4 enables out of limits, bit 5 enables interrupt request, and bit 6 selects the reference (0 = A, 1 = B). In the reference flag vectors, index 0 is reference A and index 1 is reference B.
- R3: A status pin is high exactly when at least one of its enabled flags is asserted.
- R4: The frequency lock, phase lock and interrupt request flags feed a pin whatever its reference select bit holds.
- R5: A pin's monitor flags come only from the reference its select bit names. The other reference's flags have no effect on that pin.
- R6: When both the loss-of-reference and out-of-limits enables are set, the pin asserts if either of those two flags is asserted for the selected reference.
- R7: A flag whose enable bit is clear has no effect on the pin, even while that flag is asserted. A field of all zeros holds its pin low.
- R8: Each pin is registered. It shows the result for the flags and field present at a rising edge right after that edge, so a flag change reaches the pin one clock later.
- R9: While `rst_n` is low, every control field is cleared and every status pin is low. The fields stay cleared after reset is released until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control field write enable |
| cfg_addr | input | ADDR_W (2) | Index of the pin whose field is written |
| cfg_wdata | input | 7 | New control field value |
| flag_freq_lock | input | 1 | Frequency lock flag |
| flag_phase_lock | input | 1 | Phase lock flag |
| flag_irq | input | 1 | Interrupt request flag |
| ref_invalid | input | 2 | Reference invalid flags, [0]=A, [1]=B |
| ref_lor | input | 2 | Loss-of-reference flags, [0]=A, [1]=B |
| ref_ool | input | 2 | Out-of-limits flags, [0]=A, [1]=B |
| status_pin | output | NUM_PINS (4) | Registered status pin outputs |

## Verification
The bench builds the block with the default NUM_PINS of 4, which makes every address of the 2-bit write port a real pin. Before each vector, all four fields are cleared and then one pin is set up in turn. This shows both the combining function and whether writes stay with their own field, for every pin position. The vectors pair each reference select value with monitor flags on the selected reference and on the other one, so a swap or a merge of references shows up at the pins.

// File: rtl/stpin_pkg.sv
package stpin_pkg;

    localparam int CFG_W  = 7;
    localparam int NUM_REFS = 2;

    // Field layout, most significant member first.
    typedef struct packed {
        logic ref_sel;    // bit 6: 0 = reference A, 1 = reference B
        logic en_irq;     // bit 5
        logic en_ool;     // bit 4
        logic en_lor;     // bit 3
        logic en_inv;     // bit 2
        logic en_plock;   // bit 1
        logic en_flock;   // bit 0
    } pin_cfg_t;

endpackage

// File: rtl/stpin_cfg_regs.sv
module stpin_cfg_regs
    import stpin_pkg::*;
#(
    parameter int NUM_PINS = 4,
    localparam int ADDR_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output pin_cfg_t          cfg_q [NUM_PINS]
);

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_field
        logic hit;

        always_comb begin
            hit = wr_en && (wr_addr == ADDR_W'(gi));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[gi] <= '0;
            end else if (hit) begin
                cfg_q[gi] <= pin_cfg_t'(wr_data);
            end
        end

        // R1: an addressed write lands in this field
        assert_field_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(gi)) |=> (cfg_q[gi] == pin_cfg_t'($past(wr_data))));

        // R1: a write to another index leaves this field alone
        assert_field_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == ADDR_W'(gi)) |=> $stable(cfg_q[gi]));
    end

endmodule

// File: rtl/stpin_pin_logic.sv
module stpin_pin_logic
    import stpin_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  pin_cfg_t            cfg,
    input  logic                flock,
    input  logic                plock,
    input  logic                irq,
    input  logic [NUM_REFS-1:0] ref_inv,
    input  logic [NUM_REFS-1:0] ref_lor,
    input  logic [NUM_REFS-1:0] ref_ool,
    output logic                pin_q
);

    logic sel_inv, sel_lor, sel_ool;
    logic pin_d;

    // Only the chosen reference contributes monitor flags.
    always_comb begin
        sel_inv = ref_inv[cfg.ref_sel];
        sel_lor = ref_lor[cfg.ref_sel];
        sel_ool = ref_ool[cfg.ref_sel];
    end

    always_comb begin
        pin_d = (cfg.en_flock & flock)
              | (cfg.en_plock & plock)
              | (cfg.en_irq   & irq)
              | (cfg.en_inv   & sel_inv)
              | (cfg.en_lor   & sel_lor)
              | (cfg.en_ool   & sel_ool);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= pin_d;
        end
    end

    // R7: an all-zero field keeps the pin low
    assert_zero_cfg_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == '0) |=> !pin_q);

    // R4: an enabled lock flag raises the pin one clock later
    assert_lock_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.en_flock && flock) || (cfg.en_plock && plock) || (cfg.en_irq && irq)) |=> pin_q);

    // R6: either loss or out-of-limits on the selected reference raises the pin
    assert_lor_ool_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.en_lor && ref_lor[cfg.ref_sel]) || (cfg.en_ool && ref_ool[cfg.ref_sel])) |=> pin_q);

    // R5: with only monitor enables set, the unselected reference cannot raise the pin
    assert_other_ref_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.en_flock && !cfg.en_plock && !cfg.en_irq
         && !ref_inv[cfg.ref_sel] && !ref_lor[cfg.ref_sel] && !ref_ool[cfg.ref_sel]) |=> !pin_q);

endmodule

// File: rtl/status_pin_combiner.sv
module status_pin_combiner
    import stpin_pkg::*;
#(
    parameter int NUM_PINS = 4,
    localparam int ADDR_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                flag_freq_lock,
    input  logic                flag_phase_lock,
    input  logic                flag_irq,
    input  logic [NUM_REFS-1:0] ref_invalid,
    input  logic [NUM_REFS-1:0] ref_lor,
    input  logic [NUM_REFS-1:0] ref_ool,
    output logic [NUM_PINS-1:0] status_pin
);

    pin_cfg_t cfg_q [NUM_PINS];

    stpin_cfg_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q)
    );

    for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin
        stpin_pin_logic u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg_q[gp]),
            .flock   (flag_freq_lock),
            .plock   (flag_phase_lock),
            .irq     (flag_irq),
            .ref_inv (ref_invalid),
            .ref_lor (ref_lor),
            .ref_ool (ref_ool),
            .pin_q   (status_pin[gp])
        );
    end

    // R8: with every flag low, no pin can rise on the next edge
    assert_quiet_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_freq_lock && !flag_phase_lock && !flag_irq
         && ref_invalid == '0 && ref_lor == '0 && ref_ool == '0) |=> (status_pin == '0));

endmodule

// File: tb/tb_status_pin_combiner.sv
module tb_status_pin_combiner;

    localparam int NP = 4;
    localparam int NV = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [6:0] cfg_wdata = '0;
    logic       f_fl = 1'b0, f_pl = 1'b0, f_irq = 1'b0;
    logic [1:0] r_inv = '0, r_lor = '0, r_ool = '0;
    logic [NP-1:0] status_pin;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    status_pin_combiner #(.NUM_PINS(NP)) dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
        .flag_freq_lock (f_fl), .flag_phase_lock (f_pl), .flag_irq (f_irq),
        .ref_invalid (r_inv), .ref_lor (r_lor), .ref_ool (r_ool),
        .status_pin (status_pin)
    );

    // {field[6:0], flock, plock, irq, inv_b, inv_a, lor_b, lor_a, ool_b, ool_a, expected}
    localparam logic [16:0] VEC [NV] = '{
        17'b0000001_100_000000_1,   // R3 freq lock
        17'b0000010_010_000000_1,   // R3 phase lock
        17'b0100000_001_000000_1,   // R3 irq
        17'b1000001_100_111111_1,   // R4 lock with select B
        17'b0000100_000_010000_1,   // R5 invalid A on A
        17'b0000100_000_100000_0,   // R5 invalid B ignored on A
        17'b1000100_000_100000_1,   // R5 invalid B on B
        17'b1000100_000_010000_0,   // R5 invalid A ignored on B
        17'b0011000_000_000100_1,   // R6 loss only
        17'b0011000_000_000001_1,   // R6 out of limits only
        17'b1011000_000_000101_0,   // R5 A flags, select B
        17'b0111110_100_000000_0,   // R7 freq lock disabled
        17'b0000000_111_111111_0,   // R7 all disabled
        17'b1111111_000_000010_1    // R2 out of limits B, full field
    };

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: status_pin=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [6:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(idx); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_flags(input logic [8:0] f);
        {f_fl, f_pl, f_irq, r_inv[1], r_inv[0], r_lor[1], r_lor[0], r_ool[1], r_ool[0]} = f;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R9 pins low in reset", status_pin, '0);
        rst_n = 1'b1;
        set_flags(9'h1FF);
        @(negedge clk);
        check("R9 fields clear after reset", status_pin, '0);
        set_flags('0);

        for (int v = 0; v < NV; v++) begin
            int p = v % NP;
            for (int k = 0; k < NP; k++) wr(k, 7'h00);
            set_flags('0);
            wr(p, VEC[v][16:10]);
            set_flags(VEC[v][9:1]);
            @(negedge clk);
            check($sformatf("R1/R3 vector %0d pin %0d", v, p), status_pin,
                  NP'({3'b000, VEC[v][0]} << p));
        end

        // R8: one clock latency of a flag change
        set_flags('0);
        for (int k = 0; k < NP; k++) wr(k, 7'h00);
        wr(3, 7'b0000001);
        @(negedge clk);
        f_fl = 1'b1;
        #2;
        check("R8 no change before edge", status_pin, '0);
        @(negedge clk);
        check("R8 rises after one edge", status_pin, 4'b1000);
        f_fl = 1'b0;
        @(negedge clk);
        check("R8 falls after one edge", status_pin, '0);

        // R1: several pins configured at once keep their own fields
        wr(0, 7'b0000001);
        wr(1, 7'b0000010);
        wr(2, 7'b1001000);
        f_pl = 1'b1; r_lor = 2'b10;
        @(negedge clk);
        check("R1 independent fields", status_pin, 4'b0110);
        set_flags('0);

        // R9: reset mid-run clears the fields
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 pins low during reset", status_pin, '0);
        rst_n = 1'b1;
        set_flags(9'h1FF);
        @(negedge clk);
        @(negedge clk);
        check("R9 fields cleared by reset", status_pin, '0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule